// File: doc/BRIEF.md
# VGA Attribute Port Controller

This block models the attribute-controller access port of a VGA-compatible display adapter, together with the display-mode selection that depends on it. One byte port takes both the attribute index and the attribute data. A toggle flip-flop decides which of the two each write reaches, and a read of the input-status port forces the toggle back to the index state. Software uses this sequence to reach a known state before it programs an attribute entry.

Bit 5 of the attribute index register is the palette-address-source bit, and it also acts as a blanking control. While the bit is clear, the display mode is blank. While it is set, bit 0 of graphics register 6 selects graphics or text. The registered mode output raises a one-cycle full-update pulse each time it changes value.

The register window spans byte ports 0x3C0 to 0x3DF. The same registers can also be reached at memory offsets 0x400 to 0x41F. A single input selects which of the two address maps is decoded.

Top module: `vga_attr_port`

## Requirements
- R1: After reset, the flip-flop is in the index state, a read of port 0x3C0 returns 0x00, dispMode is 0 (blank), blankOut is 1 and fullUpdate is 0.
- R2: Writes to port 0x3C0 alternate between two targets. A write in the index state loads the index register: bits 4:0 hold the attribute index and bit 5 holds the palette-address-source bit. A write in the data state loads the attribute entry that the index selects. A read of 0x3C0 returns {2'b00, index register} and does not move the flip-flop. A read of 0x3C1 returns the selected entry.
- R3: Any read of port 0x3DA puts the flip-flop in the index state and returns 0x00.
- R4: A write to 0x3C0 and a read of 0x3DA can occur in the same cycle. In that case the write acts on the flip-flop state from before the cycle, and the flip-flop ends in the index state.
- R5: The attribute file holds entries 0 to 20. A data write to index 21 or higher changes nothing, but it still returns the flip-flop to the index state. A read of 0x3C1 at such an index returns 0x00.
- R6: Port 0x3CE loads a 4-bit graphics index, and port 0x3CF accesses graphics register 6 when that index is 6. At any other index, writes to 0x3CF are dropped and reads of it return 0x00. No flip-flop is involved.
- R7: dispMode reads 0 (blank) while bit 5 of the index register is clear. With bit 5 set, it reads 2 (graphics) if bit 0 of graphics register 6 is 1, and 1 (text) otherwise. blankOut is 1 exactly when dispMode is 0. The output follows one clock after the controlling register changes.
- R8: fullUpdate is high for exactly the one cycle in which dispMode shows a new value. A register write that leaves the computed mode unchanged produces no pulse.
- R9: With viaMmio at 1, a port P is reached at address P − 0x3C0 + 0x400, with the same effects as direct port access.
- R10: A read of an address outside the active window returns 0xFF and has no side effect on the flip-flop.
- R11: A write to an address outside the active window changes no register and does not move the flip-flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| viaMmio | input | 1 | 1: decode the memory-mapped alias; 0: decode the port numbers |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 16 | Write address |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe; side effects take place at the clock edge |
| rdAddr | input | 16 | Read address |
| rdData | output | 8 | Read data for the current rdAddr, combinational |
| dispMode | output | 2 | 0 blank, 1 text, 2 graphics |
| blankOut | output | 1 | High while the display is blanked |
| fullUpdate | output | 1 | One-cycle pulse on each mode change |

## Verification
Two operations can land in the same cycle: a write to the shared index/data port, and the status read that resets its flip-flop. The bench drives both strobes together in two cases. In the first, the flip-flop is in the data state, so the write must land in the attribute entry. In the second, it is in the index state, so the write must land in the index register. In both cases, the write that follows must again be taken as an index, and this is judged by reading back the index and the selected entry.

// File: rtl/vga_attr_pkg.sv
package vga_attr_pkg;

  localparam int PORT_OFF_W = 5;

  localparam logic [PORT_OFF_W-1:0] OFF_ATTR   = 5'h00;
  localparam logic [PORT_OFF_W-1:0] OFF_ATTRRD = 5'h01;
  localparam logic [PORT_OFF_W-1:0] OFF_GFXIDX = 5'h0E;
  localparam logic [PORT_OFF_W-1:0] OFF_GFXDAT = 5'h0F;
  localparam logic [PORT_OFF_W-1:0] OFF_STATUS = 5'h1A;

  typedef enum logic [1:0] {
    MODE_BLANK = 2'd0,
    MODE_TEXT  = 2'd1,
    MODE_GRAPH = 2'd2
  } modeT;

  typedef struct packed {
    logic                  idxLoad;
    logic                  attrLoad;
    logic                  gfxIdxLoad;
    logic                  gfxDataLoad;
    logic                  rdHit;
    logic [PORT_OFF_W-1:0] rdOff;
  } ctlT;

endpackage

// File: rtl/attr_ctl.sv
module attr_ctl
  import vga_attr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              viaMmio,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output ctlT               ctl
);
  localparam logic [ADDR_W-1:0] IO_BASE = ADDR_W'(12'h3C0);
  localparam logic [ADDR_W-1:0] MM_BASE = ADDR_W'(12'h400);
  localparam logic [ADDR_W-1:0] WIN     = ADDR_W'(1 << PORT_OFF_W);

  logic [ADDR_W-1:0] base, wrDiff, rdDiff;
  logic wrHit, rdHit, attrWr, statusRd, ffData;
  logic [PORT_OFF_W-1:0] wrOff, rdOff;

  // Addresses below the base wrap around to large values and miss the window.
  assign base   = viaMmio ? MM_BASE : IO_BASE;
  assign wrDiff = wrAddr - base;
  assign rdDiff = rdAddr - base;
  assign wrHit  = wrEn && (wrDiff < WIN);
  assign rdHit  = rdEn && (rdDiff < WIN);
  assign wrOff  = wrDiff[PORT_OFF_W-1:0];
  assign rdOff  = rdDiff[PORT_OFF_W-1:0];

  assign attrWr   = wrHit && (wrOff == OFF_ATTR);
  assign statusRd = rdHit && (rdOff == OFF_STATUS);

  // The write always acts on the current flip-flop state.
  always_comb begin
    ctl.idxLoad     = attrWr && !ffData;
    ctl.attrLoad    = attrWr && ffData;
    ctl.gfxIdxLoad  = wrHit && (wrOff == OFF_GFXIDX);
    ctl.gfxDataLoad = wrHit && (wrOff == OFF_GFXDAT);
    ctl.rdHit       = rdHit;
    ctl.rdOff       = rdOff;
  end

  // A status read wins over the toggle.
  always_ff @(posedge clk) begin
    if (!rstN)         ffData <= 1'b0;
    else if (statusRd) ffData <= 1'b0;
    else if (attrWr)   ffData <= !ffData;
  end

  a_r3_status_clears: assert property (@(posedge clk) disable iff (!rstN)
    statusRd |=> !ffData);
  a_r2_port_toggles: assert property (@(posedge clk) disable iff (!rstN)
    (attrWr && !statusRd) |=> (ffData != $past(ffData)));
  a_r10_stray_read_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !rdHit && !attrWr) |=> $stable(ffData));

endmodule

// File: rtl/attr_regs.sv
module attr_regs
  import vga_attr_pkg::*;
#(
  parameter int ATTR_CNT = 21,
  parameter int DATA_W   = 8,
  parameter int GFX_IDX_W = 4,
  parameter int MODE_REG = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlT               ctl,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              pasBit,
  output logic              gfxModeBit
);
  localparam int IDX_W = PORT_OFF_W;
  localparam int IREG_W = IDX_W + 1;

  logic [IREG_W-1:0]    idxQ;
  logic [GFX_IDX_W-1:0] gfxIdxQ;
  logic [DATA_W-1:0]    modeRegQ;
  logic [DATA_W-1:0]    attrMem [ATTR_CNT];
  logic [DATA_W-1:0]    attrRd;
  logic                 gfxSel;

  assign gfxSel = (gfxIdxQ == GFX_IDX_W'(MODE_REG));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ     <= '0;
      gfxIdxQ  <= '0;
      modeRegQ <= '0;
    end else begin
      if (ctl.idxLoad)              idxQ     <= wrData[IREG_W-1:0];
      if (ctl.gfxIdxLoad)           gfxIdxQ  <= wrData[GFX_IDX_W-1:0];
      if (ctl.gfxDataLoad && gfxSel) modeRegQ <= wrData;
    end
  end

  for (genvar i = 0; i < ATTR_CNT; i++) begin : g_attr
    always_ff @(posedge clk) begin
      if (!rstN) attrMem[i] <= '0;
      else if (ctl.attrLoad && idxQ[IDX_W-1:0] == IDX_W'(i)) attrMem[i] <= wrData;
    end
  end

  always_comb begin
    attrRd = '0;
    for (int i = 0; i < ATTR_CNT; i++)
      if (idxQ[IDX_W-1:0] == IDX_W'(i)) attrRd = attrMem[i];
  end

  always_comb begin
    if (!ctl.rdHit) rdData = '1;
    else begin
      unique case (ctl.rdOff)
        OFF_ATTR:   rdData = DATA_W'(idxQ);
        OFF_ATTRRD: rdData = attrRd;
        OFF_GFXIDX: rdData = DATA_W'(gfxIdxQ);
        OFF_GFXDAT: rdData = gfxSel ? modeRegQ : '0;
        default:    rdData = '0;
      endcase
    end
  end

  assign pasBit     = idxQ[IDX_W];
  assign gfxModeBit = modeRegQ[0];

  a_r6_other_gfx_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.gfxDataLoad && !gfxSel) |=> $stable(modeRegQ));

endmodule

// File: rtl/mode_track.sv
module mode_track
  import vga_attr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pasBit,
  input  logic       gfxModeBit,
  output logic [1:0] dispMode,
  output logic       fullUpdate
);
  modeT nextMode, modeQ;

  always_comb begin
    if (!pasBit)        nextMode = MODE_BLANK;
    else if (gfxModeBit) nextMode = MODE_GRAPH;
    else                nextMode = MODE_TEXT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ      <= MODE_BLANK;
      fullUpdate <= 1'b0;
    end else begin
      fullUpdate <= (nextMode != modeQ);
      if (nextMode != modeQ) modeQ <= nextMode;
    end
  end

  assign dispMode = modeQ;

  a_r7_blank_without_pas: assert property (@(posedge clk) disable iff (!rstN)
    !pasBit |=> (modeQ == MODE_BLANK));
  a_r8_pulse_means_change: assert property (@(posedge clk) disable iff (!rstN)
    fullUpdate |-> (modeQ != $past(modeQ)));
  a_r8_change_means_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ != $past(modeQ)) |-> fullUpdate);

endmodule

// File: rtl/vga_attr_port.sv
module vga_attr_port
  import vga_attr_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int ATTR_CNT = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              viaMmio,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        dispMode,
  output logic              blankOut,
  output logic              fullUpdate
);
  ctlT  ctl;
  logic pasBit, gfxModeBit;

  attr_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rstN(rstN), .viaMmio(viaMmio),
    .wrEn(wrEn), .wrAddr(wrAddr), .rdEn(rdEn), .rdAddr(rdAddr), .ctl(ctl)
  );

  attr_regs #(.ATTR_CNT(ATTR_CNT), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData),
    .rdData(rdData), .pasBit(pasBit), .gfxModeBit(gfxModeBit)
  );

  mode_track u_mode (
    .clk(clk), .rstN(rstN), .pasBit(pasBit), .gfxModeBit(gfxModeBit),
    .dispMode(dispMode), .fullUpdate(fullUpdate)
  );

  assign blankOut = (dispMode == MODE_BLANK);

  a_r7_blank_matches_mode: assert property (@(posedge clk) disable iff (!rstN)
    blankOut == (dispMode == 2'd0));

endmodule

// File: tb/sim_vga_attr_port.sv
module sim_vga_attr_port;
  logic clk = 1'b0, rstN = 1'b0, viaMmio = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [15:0] wrAddr = '0, rdAddr = '0;
  logic [7:0] wrData = '0, rdData;
  logic [1:0] dispMode;
  logic blankOut, fullUpdate;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vga_attr_port u0 (
    .clk(clk), .rstN(rstN), .viaMmio(viaMmio), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .dispMode(dispMode), .blankOut(blankOut), .fullUpdate(fullUpdate)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); rdEn = 1; rdAddr = a; #1 d = rdData;
    @(negedge clk); rdEn = 0;
  endtask

  task automatic rdChk(input string req, input logic [15:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  // Mode and pulse one cycle after a register write, pulse gone the next.
  task automatic modeChk(input string req, input int mode, input int pulse);
    @(negedge clk);
    chk(req, dispMode, mode);
    chk(req, blankOut, mode == 0);
    chk(req, fullUpdate, pulse);
    @(negedge clk);
    chk(req, fullUpdate, 0);
  endtask

  task automatic t_reset;
    chk("R1 mode", dispMode, 0);
    chk("R1 blank", blankOut, 1);
    chk("R1 pulse", fullUpdate, 0);
    rdChk("R1 index", 16'h3C0, 8'h00);
    wr(16'h3C0, 8'h11);
    rdChk("R1 first write is index", 16'h3C0, 8'h11);
    rdChk("R3", 16'h3DA, 8'h00);
  endtask

  task automatic t_toggle;
    wr(16'h3C0, 8'h03); wr(16'h3C0, 8'h5A);
    rdChk("R2 data", 16'h3C1, 8'h5A);
    rdChk("R2 index", 16'h3C0, 8'h03);
    wr(16'h3C0, 8'h04);
    rdChk("R2 back to index", 16'h3C0, 8'h04);
    rdChk("R2 index read no toggle", 16'h3C0, 8'h04);
    wr(16'h3C0, 8'h77);
    rdChk("R2 data after index read", 16'h3C1, 8'h77);
  endtask

  task automatic t_status;
    wr(16'h3C0, 8'h07);
    rdChk("R3 status value", 16'h3DA, 8'h00);
    wr(16'h3C0, 8'h08);
    rdChk("R3 reset to index", 16'h3C0, 8'h08);
    rdChk("R3", 16'h3DA, 8'h00);
  endtask

  task automatic t_collide;
    wr(16'h3C0, 8'h01);
    @(negedge clk); wrEn = 1; wrAddr = 16'h3C0; wrData = 8'h99; rdEn = 1; rdAddr = 16'h3DA;
    @(negedge clk); wrEn = 0; rdEn = 0;
    wr(16'h3C0, 8'h01);
    rdChk("R4 data write landed", 16'h3C1, 8'h99);
    rdChk("R4 flip-flop at index", 16'h3C0, 8'h01);
    rdChk("R3", 16'h3DA, 8'h00);
    @(negedge clk); wrEn = 1; wrAddr = 16'h3C0; wrData = 8'h0A; rdEn = 1; rdAddr = 16'h3DA;
    @(negedge clk); wrEn = 0; rdEn = 0;
    rdChk("R4 index write landed", 16'h3C0, 8'h0A);
    wr(16'h3C0, 8'h0B);
    rdChk("R4 next is index", 16'h3C0, 8'h0B);
    rdChk("R3", 16'h3DA, 8'h00);
  endtask

  task automatic t_range;
    wr(16'h3C0, 8'h15); wr(16'h3C0, 8'h33);
    rdChk("R5 undefined index", 16'h3C1, 8'h00);
    wr(16'h3C0, 8'h14);
    rdChk("R5 toggled after ignored write", 16'h3C0, 8'h14);
    wr(16'h3C0, 8'h44);
    rdChk("R5 last entry", 16'h3C1, 8'h44);
  endtask

  task automatic t_mode;
    wr(16'h3CE, 8'h06); wr(16'h3CF, 8'h01);
    modeChk("R8 no pulse while blanked", 0, 0);
    rdChk("R6 reg6", 16'h3CF, 8'h01);
    wr(16'h3CE, 8'h05); wr(16'h3CF, 8'hFF);
    rdChk("R6 other index", 16'h3CF, 8'h00);
    rdChk("R6 gfx index", 16'h3CE, 8'h05);
    wr(16'h3CE, 8'h06);
    rdChk("R6 reg6 kept", 16'h3CF, 8'h01);
    rdChk("R3", 16'h3DA, 8'h00);
    wr(16'h3C0, 8'h20);
    modeChk("R7 graphics", 2, 1);
    wr(16'h3CF, 8'h00);
    modeChk("R7 text", 1, 1);
    wr(16'h3CF, 8'h02);
    modeChk("R8 same mode no pulse", 1, 0);
    wr(16'h3C0, 8'h55);
    rdChk("R3", 16'h3DA, 8'h00);
    wr(16'h3C0, 8'h00);
    modeChk("R7 blank", 0, 1);
  endtask

  task automatic t_mmio;
    viaMmio = 1;
    rdChk("R9 status via alias", 16'h041A, 8'h00);
    wr(16'h0400, 8'h03);
    rdChk("R9 index via alias", 16'h0400, 8'h03);
    rdChk("R9 data via alias", 16'h0401, 8'h5A);
    rdChk("R10 port address out of alias", 16'h03DA, 8'hFF);
    wr(16'h0400, 8'h66);
    rdChk("R10 no side effect", 16'h0401, 8'h66);
    viaMmio = 0;
    rdChk("R10 below window", 16'h03BF, 8'hFF);
    rdChk("R10 above window", 16'h03E0, 8'hFF);
  endtask

  task automatic t_stray_write;
    wr(16'h3C0, 8'h02);
    wr(16'h3E0, 8'h12);
    wr(16'h03BF, 8'h13);
    rdChk("R11 index kept", 16'h3C0, 8'h02);
    wr(16'h3C0, 8'h21);
    rdChk("R11 flip-flop kept", 16'h3C1, 8'h21);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset;
    t_toggle;
    t_status;
    t_collide;
    t_range;
    t_mode;
    t_mmio;
    t_stray_write;
    finished = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !finished; i++) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule